// File: doc/BRIEF.md
# USB Control-Endpoint Status Register Bank

This block is the CPU-facing register bank for the control endpoint of a USB device. It holds two 8-bit registers. The first is the device address word: a 7-bit address and an enable bit. The second is the endpoint-0 word: four status flags and a 4-bit mode field. Firmware reads and writes both registers through a simple strobe interface with a one-bit register select. The serial interface engine (SIE) reports protocol events through single-cycle pulses, and those pulses set the status flags.

The endpoint word protects itself against firmware. Every SIE update locks it. While it is locked, CPU writes are dropped, and a CPU read of the word releases the lock. When a write is accepted, it clears all four flags whatever data it carries. The SETUP flag is pinned high from the start of a SETUP data phase until the start of the ACK the device returns. While the SETUP flag is set, CPU writes into the endpoint FIFO are blocked.

The block also compares an incoming token address against the stored address. It chooses a handshake for the one supported mode, which answers IN and OUT with NAK and answers SETUP with ACK. Every other mode value gives a no-response code. The asynchronous active-low reset is released synchronously through a two-stage synchronizer, so the bank leaves reset two clock edges after the reset input rises.

Top module: `usb_ctl_ep_regs`

## Requirements
- R1: After reset the address word (select 0) reads 0x00. A CPU write with select 0 loads the whole byte: bit 7 is the enable and bits 6:0 are the address. A one-cycle bus-reset pulse clears the word to 0x00, and the bus reset wins over a write in the same cycle.
- R2: `addr_match` is 1 only when `tok_valid` is 1, the enable bit is 1 and `tok_addr` equals the stored address. This output is combinational.
- R3: After reset the endpoint word (select 1) reads 0x00. Its layout is: bit 7 SETUP, bit 6 IN, bit 5 OUT, bit 4 ACKed, bits 3:0 mode.
- R4: A pulse on `sie_setup_start`, `sie_in_done`, `sie_out_done` or `sie_acked` sets bit 7, 6, 5 or 4 respectively. The other flags keep their values, and the word becomes locked.
- R5: While the word is locked, a CPU write with select 1 changes no bit of the endpoint word.
- R6: A CPU read with select 1 releases the lock from the next cycle on, so a later write takes effect.
- R7: An accepted write with select 1 clears bits 7:4 for any data value and loads bits 3:0 from `cpu_wdata[3:0]`.
- R8: Bit 7 stays 1 from the `sie_setup_start` pulse through the cycle of the `sie_setup_ack` pulse, even across accepted writes. After that window, an accepted write clears it.
- R9: `fifo_we` equals `cpu_fifo_wr` while bit 7 is 0, and is 0 while bit 7 is 1.
- R10: With `addr_match` high and mode 0001, `hs_code` is 10 (NAK) for token kind 00 (OUT) or 01 (IN), 01 (ACK) for kind 10 (SETUP), and 00 (none) for kind 11. In every other case `hs_code` is 00.
- R11: When an SIE event and a CPU write with select 1 fall in the same cycle, the event is applied, the write is dropped and the word is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | USB bus-reset pulse, clears the address word |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_sel | input | 1 | Register select: 0 address word, 1 endpoint word |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| cpu_fifo_wr | input | 1 | CPU request to write the endpoint FIFO |
| fifo_we | output | 1 | Gated FIFO write enable |
| sie_setup_start | input | 1 | Start of a SETUP data phase |
| sie_setup_ack | input | 1 | Start of the ACK that closes a SETUP |
| sie_in_done | input | 1 | Last packet of an IN transaction received |
| sie_out_done | input | 1 | Last packet of an OUT transaction received |
| sie_acked | input | 1 | Transaction to the endpoint ended with ACK |
| tok_valid | input | 1 | Token present this cycle |
| tok_kind | input | 2 | Token kind: 00 OUT, 01 IN, 10 SETUP |
| tok_addr | input | 7 | Address carried by the token |
| addr_match | output | 1 | Token addressed to this enabled device |
| hs_code | output | 2 | Handshake: 00 none, 01 ACK, 10 NAK |

## Verification
Register effects of a write, an event pulse, a bus reset or a lock-releasing read are due one clock edge after the strobe. The bench drives each strobe on a falling edge and drops it on the next falling edge, so the rising edge between them is the single update, and it reads back only after that. `cpu_rdata`, `addr_match`, `hs_code` and `fifo_we` follow their inputs in the same cycle, so they are sampled 1 ns after the inputs settle and before any rising edge. The bench sweeps every address, every write byte and every mode-by-token-kind pair, and computes each expected value arithmetically.

// File: rtl/ctlep_pkg.sv
`timescale 1ns/1ps
package ctlep_pkg;
  typedef enum logic [1:0] {
    HS_NONE = 2'b00,
    HS_ACK  = 2'b01,
    HS_NAK  = 2'b10
  } hs_e;

  typedef enum logic [1:0] {
    TK_OUT   = 2'b00,
    TK_IN    = 2'b01,
    TK_SETUP = 2'b10,
    TK_RSVD  = 2'b11
  } tok_e;

  localparam int unsigned FLAG_CNT = 4;
endpackage

// File: rtl/ctlep_rst_sync.sv
`timescale 1ns/1ps
module ctlep_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ctlep_addr_reg.sv
`timescale 1ns/1ps
module ctlep_addr_reg #(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned DATA_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tok_valid,
  input  logic [ADDR_W-1:0] tok_addr,
  output logic [DATA_W-1:0] word,
  output logic              match
);
  logic              en_q, en_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              upd;

  always_comb begin
    upd    = bus_rst | wr_en;
    en_d   = en_q;
    addr_d = addr_q;
    if (bus_rst) begin
      en_d   = 1'b0;
      addr_d = '0;
    end else if (wr_en) begin
      en_d   = wdata[DATA_W-1];
      addr_d = wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else if (upd) begin
      en_q   <= en_d;
      addr_q <= addr_d;
    end
  end

  assign word  = {en_q, addr_q};
  assign match = tok_valid & en_q & (tok_addr == addr_q);

  assert_bus_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (word == '0));

  assert_write_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bus_rst) |=> (word == $past(wdata)));
endmodule

// File: rtl/ctlep_ep_reg.sv
`timescale 1ns/1ps
module ctlep_ep_reg #(
  parameter int unsigned MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ep,
  input  logic              rd_ep,
  input  logic [MODE_W-1:0] wdata_mode,
  input  logic              ev_setup_start,
  input  logic              ev_setup_ack,
  input  logic              ev_in,
  input  logic              ev_out,
  input  logic              ev_ack,
  output logic              setup_q,
  output logic              in_q,
  output logic              out_q,
  output logic              ack_q,
  output logic [MODE_W-1:0] mode_q
);
  logic              lock_q, lock_d;
  logic              hold_q, hold_d;
  logic              setup_d, in_d, out_d, ack_d;
  logic [MODE_W-1:0] mode_d;
  logic              sie_upd;
  logic              wr_ok;
  logic              ce;

  always_comb begin
    sie_upd = ev_setup_start | ev_in | ev_out | ev_ack;
    wr_ok   = wr_ep & ~lock_q & ~sie_upd;
    ce      = sie_upd | wr_ok | rd_ep | ev_setup_ack;

    setup_d = (wr_ok ? 1'b0 : setup_q) | ev_setup_start | hold_q;
    in_d    = (wr_ok ? 1'b0 : in_q)    | ev_in;
    out_d   = (wr_ok ? 1'b0 : out_q)   | ev_out;
    ack_d   = (wr_ok ? 1'b0 : ack_q)   | ev_ack;
    mode_d  = wr_ok ? wdata_mode : mode_q;

    if (ev_setup_start)    hold_d = 1'b1;
    else if (ev_setup_ack) hold_d = 1'b0;
    else                   hold_d = hold_q;

    if (sie_upd)    lock_d = 1'b1;
    else if (rd_ep) lock_d = 1'b0;
    else            lock_d = lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= 1'b0;
      in_q    <= 1'b0;
      out_q   <= 1'b0;
      ack_q   <= 1'b0;
      mode_q  <= '0;
      hold_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else if (ce) begin
      setup_q <= setup_d;
      in_q    <= in_d;
      out_q   <= out_d;
      ack_q   <= ack_d;
      mode_q  <= mode_d;
      hold_q  <= hold_d;
      lock_q  <= lock_d;
    end
  end

  assert_event_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_in || ev_out || ev_ack) |=>
      ((in_q || !$past(ev_in)) && (out_q || !$past(ev_out)) && (ack_q || !$past(ev_ack))));

  assert_locked_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_ep && !sie_upd && !hold_q) |=> $stable({setup_q, in_q, out_q, ack_q, mode_q}));

  assert_read_unlocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ep && !sie_upd) |=> !lock_q);

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ep && !lock_q && !sie_upd) |=>
      (!in_q && !out_q && !ack_q && (mode_q == $past(wdata_mode))));

  assert_setup_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> setup_q);

  assert_sie_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ep && sie_upd) |=> (lock_q && $stable(mode_q)));
endmodule

// File: rtl/ctlep_policy.sv
`timescale 1ns/1ps
module ctlep_policy
  import ctlep_pkg::*;
#(
  parameter int unsigned MODE_W   = 4,
  parameter logic [MODE_W-1:0] NAK_MODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_match,
  input  logic [1:0]        tok_kind,
  input  logic [MODE_W-1:0] mode,
  input  logic              setup_flag,
  input  logic              fifo_req,
  output logic [1:0]        hs_code,
  output logic              fifo_we
);
  hs_e hs;

  always_comb begin
    hs = HS_NONE;
    if (addr_match && (mode == NAK_MODE)) begin
      unique case (tok_kind)
        TK_OUT, TK_IN: hs = HS_NAK;
        TK_SETUP:      hs = HS_ACK;
        default:       hs = HS_NONE;
      endcase
    end
  end

  assign hs_code = hs;
  assign fifo_we = fifo_req & ~setup_flag;

  assert_fifo_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    setup_flag |-> !fifo_we);

  assert_hs_needs_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code != HS_NONE) |-> (addr_match && (mode == NAK_MODE)));
endmodule

// File: rtl/usb_ctl_ep_regs.sv
`timescale 1ns/1ps
module usb_ctl_ep_regs #(
  parameter int unsigned ADDR_W = 7,
  parameter logic [3:0]  NAK_MODE = 4'b0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic              cpu_sel,
  input  logic [ADDR_W:0]   cpu_wdata,
  output logic [ADDR_W:0]   cpu_rdata,
  input  logic              cpu_fifo_wr,
  output logic              fifo_we,
  input  logic              sie_setup_start,
  input  logic              sie_setup_ack,
  input  logic              sie_in_done,
  input  logic              sie_out_done,
  input  logic              sie_acked,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [ADDR_W-1:0] tok_addr,
  output logic              addr_match,
  output logic [1:0]        hs_code
);
  localparam int unsigned DATA_W = ADDR_W + 1;
  localparam int unsigned MODE_W = DATA_W - ctlep_pkg::FLAG_CNT;

  logic              rst_n_s;
  logic              wr_addr, wr_ep, rd_ep;
  logic [DATA_W-1:0] addr_word;
  logic              setup_f, in_f, out_f, ack_f;
  logic [MODE_W-1:0] mode_f;
  logic [DATA_W-1:0] ep_word;

  assign wr_addr = cpu_wr & ~cpu_sel;
  assign wr_ep   = cpu_wr & cpu_sel;
  assign rd_ep   = cpu_rd & cpu_sel;

  ctlep_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  ctlep_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .bus_rst  (bus_rst),
    .wr_en    (wr_addr),
    .wdata    (cpu_wdata),
    .tok_valid(tok_valid),
    .tok_addr (tok_addr),
    .word     (addr_word),
    .match    (addr_match)
  );

  ctlep_ep_reg #(.MODE_W(MODE_W)) u_ep (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .wr_ep         (wr_ep),
    .rd_ep         (rd_ep),
    .wdata_mode    (cpu_wdata[MODE_W-1:0]),
    .ev_setup_start(sie_setup_start),
    .ev_setup_ack  (sie_setup_ack),
    .ev_in         (sie_in_done),
    .ev_out        (sie_out_done),
    .ev_ack        (sie_acked),
    .setup_q       (setup_f),
    .in_q          (in_f),
    .out_q         (out_f),
    .ack_q         (ack_f),
    .mode_q        (mode_f)
  );

  ctlep_policy #(.MODE_W(MODE_W), .NAK_MODE(NAK_MODE[MODE_W-1:0])) u_pol (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .addr_match(addr_match),
    .tok_kind  (tok_kind),
    .mode      (mode_f),
    .setup_flag(setup_f),
    .fifo_req  (cpu_fifo_wr),
    .hs_code   (hs_code),
    .fifo_we   (fifo_we)
  );

  assign ep_word   = {setup_f, in_f, out_f, ack_f, mode_f};
  assign cpu_rdata = cpu_sel ? ep_word : addr_word;
endmodule

// File: tb/test_usb_ctl_ep_regs.sv
`timescale 1ns/1ps
module test_usb_ctl_ep_regs;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, bus_rst, cpu_wr, cpu_rd, cpu_sel, cpu_fifo_wr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       fifo_we, sie_setup_start, sie_setup_ack, sie_in_done, sie_out_done, sie_acked;
  logic       tok_valid, addr_match;
  logic [1:0] tok_kind, hs_code;
  logic [6:0] tok_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ctl_ep_regs i_usb_ctl_ep_regs (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_fifo_wr(cpu_fifo_wr), .fifo_we(fifo_we), .sie_setup_start(sie_setup_start),
    .sie_setup_ack(sie_setup_ack), .sie_in_done(sie_in_done), .sie_out_done(sie_out_done),
    .sie_acked(sie_acked), .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_addr(tok_addr),
    .addr_match(addr_match), .hs_code(hs_code)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1;
    step();
    cpu_wr = 1'b0;
  endtask

  // read: sample combinational data, then let the edge see the strobe
  task automatic rd(input logic sel, output logic [7:0] d);
    cpu_sel = sel; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    step();
    cpu_rd = 1'b0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: sie_setup_start = 1'b1;
      1: sie_setup_ack   = 1'b1;
      2: sie_in_done     = 1'b1;
      3: sie_out_done    = 1'b1;
      default: sie_acked = 1'b1;
    endcase
    step();
    {sie_setup_start, sie_setup_ack, sie_in_done, sie_out_done, sie_acked} = '0;
  endtask

  function automatic logic [1:0] exp_hs(input logic m, input logic [3:0] mode, input logic [1:0] k);
    if (!m || mode != 4'd1) return 2'b00;
    if (k == 2'b10) return 2'b01;
    if (k[1] == 1'b0) return 2'b10;
    return 2'b00;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; bus_rst = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_sel = 1'b0;
    cpu_wdata = '0; cpu_fifo_wr = 1'b0; tok_valid = 1'b0; tok_kind = '0; tok_addr = '0;
    {sie_setup_start, sie_setup_ack, sie_in_done, sie_out_done, sie_acked} = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 R3 reset state
    rd(1'b0, v); chk("R1 reset addr", v, 8'h00);
    rd(1'b1, v); chk("R3 reset ep", v, 8'h00);

    // R1 R2 sweep of all addresses
    for (int a = 0; a < 128; a++) begin
      wr(1'b0, {1'b1, 7'(a)});
      rd(1'b0, v); chk("R1 addr load", v, {1'b1, 7'(a)});
      tok_valid = 1'b1; tok_addr = 7'(a);
      #1 chk("R2 match equal", {7'b0, addr_match}, 8'h01);
      tok_addr = 7'(a) ^ 7'h15;
      #1 chk("R2 match differ", {7'b0, addr_match}, 8'h00);
      tok_addr = 7'(a); tok_valid = 1'b0;
      #1 chk("R2 no token", {7'b0, addr_match}, 8'h00);
      step();
    end
    wr(1'b0, 8'h33);
    tok_valid = 1'b1; tok_addr = 7'h33;
    #1 chk("R2 disabled", {7'b0, addr_match}, 8'h00);
    tok_valid = 1'b0;
    step();

    // R1 bus reset
    wr(1'b0, 8'hA5);
    bus_rst = 1'b1; step(); bus_rst = 1'b0;
    rd(1'b0, v); chk("R1 bus reset clears", v, 8'h00);
    tok_valid = 1'b1; tok_addr = 7'h25;
    #1 chk("R1 match after bus reset", {7'b0, addr_match}, 8'h00);
    tok_valid = 1'b0;
    wr(1'b0, 8'hC1);
    cpu_wr = 1'b1; cpu_sel = 1'b0; cpu_wdata = 8'h9F; bus_rst = 1'b1;
    step(); cpu_wr = 1'b0; bus_rst = 1'b0;
    rd(1'b0, v); chk("R1 bus reset beats write", v, 8'h00);

    // R7 sweep of every write byte
    for (int d = 0; d < 256; d++) begin
      wr(1'b1, 8'(d));
      rd(1'b1, v); chk("R7 clear on write", v, {4'h0, 4'(d)});
    end

    // R4 R5 R6 flags, lock, unlock
    wr(1'b1, 8'h06);
    pulse(2);
    rd(1'b1, v); chk("R4 IN flag bit6", v, 8'h46);
    pulse(3);
    wr(1'b1, 8'h0A);
    rd(1'b1, v); chk("R5 locked write ignored", v, 8'h66);
    pulse(4);
    wr(1'b1, 8'hF2);
    wr(1'b1, 8'h01);
    rd(1'b1, v); chk("R4 ACK flag bit4", v, 8'h76);
    wr(1'b1, 8'hF9);
    rd(1'b1, v); chk("R6 write after unlocking read", v, 8'h09);

    // R11 collision
    cpu_sel = 1'b1; cpu_wdata = 8'h0F; cpu_wr = 1'b1; sie_out_done = 1'b1;
    step(); cpu_wr = 1'b0; sie_out_done = 1'b0;
    wr(1'b1, 8'h03);
    rd(1'b1, v); chk("R11 event wins, lock set", v, 8'h29);

    // R8 R9 SETUP window
    wr(1'b1, 8'h01);
    cpu_fifo_wr = 1'b1;
    #1 chk("R9 fifo open", {7'b0, fifo_we}, 8'h01);
    pulse(0);
    #1 chk("R9 fifo blocked", {7'b0, fifo_we}, 8'h00);
    rd(1'b1, v); chk("R4 SETUP flag bit7", v, 8'h81);
    wr(1'b1, 8'h05);
    rd(1'b1, v); chk("R8 SETUP held across write", v, 8'h85);
    wr(1'b1, 8'h02);
    rd(1'b1, v); chk("R8 SETUP held again", v, 8'h82);
    pulse(1);
    rd(1'b1, v); chk("R8 flag stays until write", v, 8'h82);
    #1 chk("R9 still blocked", {7'b0, fifo_we}, 8'h00);
    wr(1'b1, 8'h03);
    rd(1'b1, v); chk("R8 cleared after window", v, 8'h03);
    #1 chk("R9 fifo reopens", {7'b0, fifo_we}, 8'h01);
    cpu_fifo_wr = 1'b0;
    #1 chk("R9 no request", {7'b0, fifo_we}, 8'h00);

    // R10 sweep of mode x token kind, matched and unmatched
    wr(1'b0, 8'hAA);
    for (int m = 0; m < 16; m++) begin
      wr(1'b1, 8'(m));
      for (int k = 0; k < 4; k++) begin
        tok_valid = 1'b1; tok_kind = 2'(k);
        tok_addr = 7'h2A;
        #1 chk("R10 handshake matched", {6'b0, hs_code}, {6'b0, exp_hs(1'b1, 4'(m), 2'(k))});
        tok_addr = 7'h2B;
        #1 chk("R10 handshake unmatched", {6'b0, hs_code}, {6'b0, exp_hs(1'b0, 4'(m), 2'(k))});
      end
      tok_valid = 1'b0;
      step();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule